// File: doc/BRIEF.md
# ADC Sample Buffer with Interrupt

This block collects tagged conversion results from an analog-to-digital converter and stores them in an on-chip FIFO. A host drains the FIFO through a small strobe-based register port. One read address pops the oldest sample. A second address returns a status word and accepts a control byte. Two more write-only addresses act as strobes: one flushes the FIFO and the other acknowledges the interrupt.

The block raises a pending-interrupt flag in one of two modes, chosen by a control bit. In per-sample mode the flag is raised by every stored sample. In half-full mode it is raised once, on the move of the fill level from below half to half or above. The host polls the pending bit to learn whether an interrupt came from this device. The interrupt pin is the pending flag gated by an enable bit.

Writing the sample address does not touch the FIFO. It sends a one-cycle software conversion trigger to the converter. When a sample arrives into a full FIFO, it is thrown away and a sticky overrun flag is set. Only a flush clears that flag.

The converter side is a valid/ready stream with no back-pressure. `adc_ready` is held high, so the converter never stalls. Overruns are absorbed inside the block instead.

Top module: `adc_fifo_irq`

## Requirements
- R1: After reset, the status word reads 0x0100: only the empty flag (bit 8) is set and the control byte is zero. `irq` and `soft_trig` are low.
- R2: Samples accepted on the stream are returned in arrival order by reads of address 0. Read data appears on `host_rdata` in the cycle after the read strobe.
- R3: A read of address 0 while the FIFO is empty returns the last value popped. It leaves the FIFO empty, and a later sample is stored and read back normally.
- R4: Status bit 9 is set while the fill level is at least DEPTH/2 (512 for the default depth of 1024).
- R5: A sample that arrives while the FIFO holds DEPTH entries is discarded. Status bit 10 becomes set at that point, or when the last free slot is filled. It stays set through reads until a flush.
- R6: With control bit 5 clear, every stored sample sets the pending flag (status bit 11).
- R7: With control bit 5 set, the pending flag is set only when the fill level rises from DEPTH/2-1 to DEPTH/2. Further samples above the threshold do not set it again.
- R8: A write to address 2 clears the pending flag. An interrupt event in the same cycle wins.
- R9: A write to address 3 empties the FIFO and clears the half and overrun flags. It leaves the pending flag and the last popped value unchanged. A sample arriving in that same cycle is discarded.
- R10: `irq` equals the pending flag ANDed with control bit 4. With the enable low, the pending bit still shows in status. The status low byte reads back the control byte written at address 1.
- R11: A write to address 0 drives `soft_trig` high for exactly the next cycle and does not change the FIFO.
- R12: `adc_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_valid | input | 1 | Converter sample valid |
| adc_data | input | DATA_W | Tagged conversion result |
| adc_ready | output | 1 | Always high; overruns are dropped internally |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 sample/trigger, 1 status/control, 2 clear interrupt, 3 flush |
| host_wdata | input | 8 | Control byte (bit 4 enable, bit 5 half-full mode) |
| host_rdata | output | DATA_W | Read data, valid the cycle after `host_rd` |
| irq | output | 1 | Level interrupt |
| soft_trig | output | 1 | One-cycle software conversion trigger |

## Verification
A short table drives a few tagged samples and interleaves pops, status reads and an acknowledge. This separates ordering errors from flag errors and shows whether an empty read disturbs the pointers.

Half-full mode is driven up to the threshold one sample at a time. The FIFO is then pulled back below the threshold and refilled. This distinguishes an edge-triggered flag from a level-held one.

A full run of DEPTH samples, plus one extra, checks that the extra sample is dropped rather than overwriting data. It also shows that the overrun flag persists after draining.

Enable and acknowledge toggles while a flag is pending distinguish the gating of the pin from the pending state itself.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  // host address map
  localparam logic [1:0] ADDR_SAMPLE  = 2'd0;
  localparam logic [1:0] ADDR_CSR     = 2'd1;
  localparam logic [1:0] ADDR_ACK     = 2'd2;
  localparam logic [1:0] ADDR_FLUSH   = 2'd3;
  // status word bit positions
  localparam int ST_EMPTY   = 8;
  localparam int ST_HALF    = 9;
  localparam int ST_OVERRUN = 10;
  localparam int ST_PENDING = 11;
  // control byte bit positions
  localparam int CT_IEN     = 4;
  localparam int CT_HALFMODE = 5;
endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CW-1:0]     fill,
  output logic              empty,
  output logic              half,
  output logic              overrun,
  output logic              stored
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign do_push = push && !flush && (fill != FULL_LVL);
  assign do_pop  = pop && !flush && (fill != '0);
  assign stored  = do_push;
  assign empty   = (fill == '0);
  assign half    = (fill >= HALF_LVL);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      dout    <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        dout   <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if ((push && !do_push) || (do_push && !do_pop && fill == FULL_LVL - 1'b1))
        overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic half_mode,
  input  logic irq_en,
  input  logic stored,
  input  logic half,
  input  logic ack,
  output logic pending,
  output logic irq
);
  logic half_q, half_rise, event_hit;

  assign half_rise = half && !half_q;
  assign event_hit = half_mode ? half_rise : stored;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      half_q <= half;
      if (event_hit)  pending <= 1'b1;
      else if (ack)   pending <= 1'b0;
    end
  end

  assign irq = pending && irq_en;
endmodule

// File: rtl/adc_fifo_irq.sv
module adc_fifo_irq
  import adc_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_ready,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              soft_trig
);
  logic [7:0]        ctrl_q;
  logic              ctrl_ien, ctrl_halfmode;
  logic              wr_sample, wr_csr, wr_ack, wr_flush, rd_sample;
  logic [DATA_W-1:0] fifo_dout, status_w, status_q;
  logic [CW-1:0]     fill_cnt;
  logic              fifo_empty, fifo_half, full_sticky, stored, pending;
  logic              sel_sample_q;

  assign wr_sample = host_wr && host_addr == ADDR_SAMPLE;
  assign wr_csr    = host_wr && host_addr == ADDR_CSR;
  assign wr_ack    = host_wr && host_addr == ADDR_ACK;
  assign wr_flush  = host_wr && host_addr == ADDR_FLUSH;
  assign rd_sample = host_rd && host_addr == ADDR_SAMPLE;

  assign ctrl_ien      = ctrl_q[CT_IEN];
  assign ctrl_halfmode = ctrl_q[CT_HALFMODE];
  assign adc_ready     = 1'b1;

  adc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(wr_flush),
    .push(adc_valid), .din(adc_data), .pop(rd_sample),
    .dout(fifo_dout), .fill(fill_cnt), .empty(fifo_empty),
    .half(fifo_half), .overrun(full_sticky), .stored(stored)
  );

  adc_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .half_mode(ctrl_halfmode), .irq_en(ctrl_ien),
    .stored(stored), .half(fifo_half), .ack(wr_ack),
    .pending(pending), .irq(irq)
  );

  always_comb begin
    status_w             = '0;
    status_w[7:0]        = ctrl_q;
    status_w[ST_EMPTY]   = fifo_empty;
    status_w[ST_HALF]    = fifo_half;
    status_w[ST_OVERRUN] = full_sticky;
    status_w[ST_PENDING] = pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      soft_trig    <= 1'b0;
      sel_sample_q <= 1'b0;
      status_q     <= '0;
    end else begin
      soft_trig <= wr_sample;
      if (wr_csr) ctrl_q <= host_wdata;
      if (host_rd) begin
        sel_sample_q <= (host_addr == ADDR_SAMPLE);
        status_q     <= status_w;
      end
    end
  end

  assign host_rdata = sel_sample_q ? fifo_dout : status_q;
endmodule

// File: rtl/adc_fifo_irq_chk.sv
module adc_fifo_irq_chk
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [1:0]    host_addr,
  input logic          adc_valid,
  input logic [CW-1:0] fill_cnt,
  input logic          fifo_empty,
  input logic          full_sticky,
  input logic          ctrl_ien,
  input logic          irq,
  input logic          soft_trig
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == ADDR_SAMPLE && fifo_empty && !adc_valid && !host_wr
    |=> fill_cnt == '0);

  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full_sticky && !(host_wr && host_addr == ADDR_FLUSH) |=> full_sticky);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == ADDR_FLUSH |=> fifo_empty && !full_sticky);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ien |-> !irq);

  a_r11_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == ADDR_SAMPLE |=> soft_trig && $stable(fill_cnt));
endmodule

bind adc_fifo_irq adc_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .adc_valid(adc_valid), .fill_cnt(fill_cnt),
  .fifo_empty(fifo_empty), .full_sticky(full_sticky), .ctrl_ien(ctrl_ien),
  .irq(irq), .soft_trig(soft_trig)
);

// File: tb/tb_adc_fifo_irq.sv
module tb_adc_fifo_irq;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              adc_valid = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              adc_ready;
  logic              host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]        host_addr = '0;
  logic [7:0]        host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              irq, soft_trig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_fifo_irq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
    .adc_ready(adc_ready), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .soft_trig(soft_trig)
  );

  // {kind, value, expected}; kind 0 push, 1 pop+check, 2 status check, 3 ack
  localparam logic [33:0] TBL [14] = '{
    {2'd0, 16'h1234, 16'h0000},
    {2'd0, 16'h2345, 16'h0000},
    {2'd0, 16'h3456, 16'h0000},
    {2'd2, 16'h0000, 16'h0800},  // R6 pending from samples, R4 not half
    {2'd1, 16'h0000, 16'h1234},  // R2 order
    {2'd1, 16'h0000, 16'h2345},
    {2'd3, 16'h0000, 16'h0000},
    {2'd2, 16'h0000, 16'h0000},  // R8 ack clears pending
    {2'd1, 16'h0000, 16'h3456},
    {2'd2, 16'h0000, 16'h0100},
    {2'd1, 16'h0000, 16'h3456},  // R3 empty read keeps last
    {2'd0, 16'hBEEF, 16'h0000},
    {2'd1, 16'h0000, 16'hBEEF},  // R3 no underflow
    {2'd2, 16'h0000, 16'h0900}
  };

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [DATA_W-1:0] v);
    @(negedge clk);
    adc_valid = 1'b1; adc_data = v;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, R12 ready
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 soft_trig", {15'd0, soft_trig}, 16'd0);
    chk("R12 adc_ready", {15'd0, adc_ready}, 16'd1);
    hread(2'd1, v);
    chk("R1 status", v, 16'h0100);

    // table walk
    for (int i = 0; i < 14; i++) begin
      case (TBL[i][33:32])
        2'd0: push(TBL[i][31:16]);
        2'd1: begin hread(2'd0, v); chk("R2/R3 table pop", v, TBL[i][15:0]); end
        2'd2: begin idle(1); hread(2'd1, v); chk("R6/R8 table status", v, TBL[i][15:0]); end
        default: hwrite(2'd2, 8'h00);
      endcase
      idle(1);
    end

    // R10 gating of pending by enable
    hwrite(2'd1, 8'h10);
    chk("R10 irq enabled", {15'd0, irq}, 16'd1);
    hwrite(2'd1, 8'h00);
    chk("R10 irq disabled", {15'd0, irq}, 16'd0);
    hread(2'd1, v);
    chk("R10 pending visible", v, 16'h0900);
    hwrite(2'd2, 8'h00);
    hread(2'd1, v);
    chk("R8 ack", v, 16'h0100);

    // R11 software trigger
    hwrite(2'd0, 8'h00);
    chk("R11 trig high", {15'd0, soft_trig}, 16'd1);
    idle(1);
    chk("R11 trig low", {15'd0, soft_trig}, 16'd0);
    hread(2'd1, v);
    chk("R11 fifo untouched", v, 16'h0100);

    // R7/R4 half-full mode
    hwrite(2'd1, 8'h30);
    hwrite(2'd3, 8'h00);
    hwrite(2'd2, 8'h00);
    for (int k = 0; k < DEPTH / 2 - 1; k++) push(16'(k));
    idle(2);
    hread(2'd1, v);
    chk("R7 below half", v, 16'h0030);
    push(16'h0AAA);
    idle(2);
    hread(2'd1, v);
    chk("R7/R4 half crossing", v, 16'h0A30);
    chk("R10 irq half", {15'd0, irq}, 16'd1);
    hwrite(2'd2, 8'h00);
    push(16'h0BBB);
    idle(2);
    hread(2'd1, v);
    chk("R7 no re-raise above half", v, 16'h0230);
    hread(2'd0, v);
    hread(2'd0, v);
    idle(1);
    hread(2'd1, v);
    chk("R4 below half again", v, 16'h0030);
    push(16'h0CCC);
    idle(2);
    hread(2'd1, v);
    chk("R7 second crossing", v, 16'h0A30);

    // R5 overrun, R2 order over full depth
    hwrite(2'd1, 8'h00);
    hwrite(2'd3, 8'h00);
    hwrite(2'd2, 8'h00);
    for (int k = 0; k < DEPTH; k++) push(16'h4000 + 16'(k));
    idle(2);
    hread(2'd1, v);
    chk("R5 full status", v, 16'h0E00);
    push(16'hDEAD);
    for (int k = 0; k < DEPTH; k++) begin
      hread(2'd0, v);
      chk("R2/R5 drain order", v, 16'h4000 + 16'(k));
    end
    idle(1);
    hread(2'd1, v);
    chk("R5 overrun sticky", v, 16'h0D00);
    hread(2'd0, v);
    chk("R3 empty read after drain", v, 16'h43FF);

    // R9 flush
    push(16'h1111);
    push(16'h2222);
    hwrite(2'd3, 8'h00);
    hread(2'd1, v);
    chk("R9 flush status", v, 16'h0900);
    hread(2'd0, v);
    chk("R9 last value kept", v, 16'h43FF);
    hwrite(2'd2, 8'h00);
    hread(2'd1, v);
    chk("R8 final ack", v, 16'h0100);

    finish_run();
  end
endmodule